// File: doc/BRIEF.md
# Serial Packet Handshake Sequencer

This block sits between a byte-wide packet queue and a UART serializer/deserializer pair and runs the active-low request/clear handshakes that frame each packet on the wire. On the receive side it answers a partner's request with a clear signal and enables the deserializer. It also watches the spacing between received bytes and reports a packet that stalls. On the transmit side it raises its own request, waits for the partner's permission and then streams the queued packet into the serializer. It drops the request once the last stop bit has left the line.

Three behaviours are selected by a two-bit mode input. With no flow control, only the data paths move. In the edge-handshake mode, transmission starts only on a falling edge of the partner's clear, and a new request waits until that clear has gone high again. In the level-handshake mode, a low clear level (a tied-low pin is fine) permits sending, and a minimum idle gap is enforced between packets. All time limits are given in milliseconds and converted to clock cycles through a cycles-per-millisecond parameter.

Top module: `pkt_flow_ctrl`

## Requirements
- R1: After reset `rx_clr_n` and `tx_rts_n` are high, and `ser_valid`, `tx_tmo` and `rx_abort` are low.
- R2: Mode code 0 (and the spare code 3) uses no flow control. `tx_rts_n` and `rx_clr_n` stay high, `rx_en` is high, and a pending packet is streamed with no wait for `tx_cts_n`.
- R3: Mode code 1, receive side: within 4 cycles of `rx_req_n` going low, `rx_clr_n` goes low and `rx_en` goes high. Within 4 cycles of `rx_req_n` going high, `rx_clr_n` goes high and `rx_en` goes low.
- R4: Mode code 1, transmit side: with a packet pending and `tx_cts_n` high, `tx_rts_n` goes low. No byte is offered until a falling edge of `tx_cts_n` is seen. While `tx_cts_n` is still low from an earlier transfer, `tx_rts_n` is withheld.
- R5: Mode code 1: once the first byte has moved, raising `tx_cts_n` does not stop the packet. Every remaining byte is delivered.
- R6: `tx_rts_n` returns high within 2 cycles after `ser_idle` rises following the byte marked last.
- R7: Mode code 2, transmit side: a low level on `tx_cts_n` permits sending. After a packet, `tx_rts_n` stays high for at least GAP_MS milliseconds of clock cycles before the next request.
- R8: Mode code 2, receive side: `rx_en` stays high regardless of `rx_req_n`, and `rx_clr_n` still answers `rx_req_n` as in R3.
- R9: If `tx_cts_n` does not grant a request within CLR_TMO_MS milliseconds, `tx_tmo` is set and remains set after the packet. It is cleared when the next request is raised.
- R10: After a received byte (`des_valid`), if neither another byte nor `rx_eop` arrives within ABORT_MS milliseconds, `rx_abort` pulses high for one cycle. An `rx_eop` disarms the check.
- R11: A byte moves only when `ser_valid` and `ser_ready` are both high. `ser_data` equals `src_data`, and bytes leave in queue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0/3 no flow control, 1 edge handshake, 2 level handshake |
| rx_req_n | input | 1 | Partner receive request, active low (asynchronous) |
| rx_clr_n | output | 1 | Receive clear to partner, active low |
| rx_en | output | 1 | Deserializer enable |
| des_valid | input | 1 | One-cycle strobe per received byte |
| rx_eop | input | 1 | One-cycle strobe at received packet end |
| rx_abort | output | 1 | One-cycle pulse on an inter-byte gap timeout |
| pkt_pend | input | 1 | A transmit packet is queued |
| src_valid | input | 1 | Queue byte valid |
| src_data | input | DW | Queue byte |
| src_last | input | 1 | Queue byte is the packet's last |
| src_ready | output | 1 | Queue byte taken |
| ser_valid | output | 1 | Byte offered to serializer |
| ser_data | output | DW | Byte to serializer |
| ser_ready | input | 1 | Serializer accepts a byte |
| ser_idle | input | 1 | Serializer line idle after stop bit |
| tx_rts_n | output | 1 | Transmit request to partner, active low |
| tx_cts_n | input | 1 | Partner transmit clear, active low (asynchronous) |
| tx_tmo | output | 1 | Clear-wait timeout status |

## Verification
The transmit path is driven with packets under each mode while the partner's clear is held high, held low from before the request, dropped on an edge, and raised mid-packet. These patterns separate edge detection from level detection and show that a mid-packet withdrawal is ignored. A scoreboard compares every byte the serializer model takes against the queued order, so a lost, repeated or reordered byte is caught whatever the handshake timing. Request-to-request spacing in level mode, clear-wait timeouts, and received-byte gaps both with and without an end-of-packet strobe are measured in cycles. This shows the three timers fire at their limits and not before.

// File: rtl/pfc_pkg.sv
// Shared types for the packet handshake sequencer.
package pfc_pkg;
    typedef enum logic [1:0] {
        MODE_RAW   = 2'd0,
        MODE_EDGE  = 2'd1,
        MODE_LEVEL = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_REQ,
        TX_SEND,
        TX_DRAIN,
        TX_GAP
    } tx_st_e;
endpackage

// File: rtl/pfc_sync.sv
// Multi-stage synchronizer for asynchronous active-low handshake inputs.
// Assumes inputs idle high; every stage resets to ones.
module pfc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    // first stage captures the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= '1;
        else        st[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // later stages shift the captured value along
        always_ff @(posedge clk) begin
            if (!rst_n) st[i] <= '1;
            else        st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/pfc_ms_timer.sv
// Millisecond window timer: counts clock cycles while run is high and
// flags expiry after LIMIT_MS * CLK_PER_MS cycles. Clears when run drops
// or restart pulses. Assumes the product fits a 32-bit integer.
module pfc_ms_timer #(
    parameter int CLK_PER_MS = 125000,
    parameter int LIMIT_MS   = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int LIM = LIMIT_MS * CLK_PER_MS;
    localparam int W   = $clog2(LIM + 1);
    localparam logic [W-1:0] LIM_V = W'(LIM);

    logic [W-1:0] cnt;

    // cycle counter, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (!run || restart) cnt <= '0;
        else if (cnt != LIM_V)   cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LIM_V);
endmodule

// File: rtl/pfc_rx_ctrl.sv
// Receive side: answers the partner's request with a clear, enables the
// deserializer and watches inter-byte gaps. Assumes req_n_s is already
// synchronized and that the partner holds request high until clear rises.
module pfc_rx_ctrl
    import pfc_pkg::*;
#(
    parameter int CLK_PER_MS = 125000,
    parameter int ABORT_MS   = 100
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  req_n_s,
    input  logic  des_valid,
    input  logic  rx_eop,
    output logic  rx_clr_n,
    output logic  rx_en,
    output logic  rx_abort
);
    logic active;
    logic armed;
    logic gap_exp;

    pfc_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .LIMIT_MS(ABORT_MS)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (armed),
        .restart (des_valid),
        .expired (gap_exp)
    );

    // handshake state: clear follows the partner's request level
    always_ff @(posedge clk) begin
        if (!rst_n)                  active <= 1'b0;
        else if (mode == MODE_RAW)   active <= 1'b0;
        else if (!active && !req_n_s) active <= 1'b1;
        else if (active && req_n_s)  active <= 1'b0;
    end

    // gap watchdog arming: a byte arms, packet end or expiry disarms
    always_ff @(posedge clk) begin
        if (!rst_n)        armed <= 1'b0;
        else if (rx_eop)   armed <= 1'b0;
        else if (des_valid) armed <= 1'b1;
        else if (gap_exp)  armed <= 1'b0;
        else if (mode == MODE_EDGE && active && req_n_s) armed <= 1'b0;
    end

    // single-cycle abort report
    always_ff @(posedge clk) begin
        if (!rst_n) rx_abort <= 1'b0;
        else        rx_abort <= armed && gap_exp && !des_valid && !rx_eop;
    end

    assign rx_clr_n = ~active;
    assign rx_en    = (mode == MODE_EDGE) ? active : 1'b1;
endmodule

// File: rtl/pfc_tx_ctrl.sv
// Transmit side: raises the request, waits for the partner's clear
// (edge or level per mode), streams one packet and holds the request
// until the serializer line is idle. Assumes cts_n_s is synchronized and
// that ser_idle falls in the cycle after an accepted byte.
module pfc_tx_ctrl
    import pfc_pkg::*;
#(
    parameter int DW         = 8,
    parameter int CLK_PER_MS = 125000,
    parameter int CLR_TMO_MS = 22,
    parameter int GAP_MS     = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode,
    input  logic          cts_n_s,
    input  logic          pkt_pend,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    input  logic          src_last,
    output logic          src_ready,
    output logic          ser_valid,
    output logic [DW-1:0] ser_data,
    input  logic          ser_ready,
    input  logic          ser_idle,
    output logic          tx_rts_n,
    output logic          tx_tmo
);
    tx_st_e st, st_nx;
    logic   cts_n_d;
    logic   req_exp;
    logic   gap_exp;
    logic   cts_fall;
    logic   take_last;

    pfc_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .LIMIT_MS(CLR_TMO_MS)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st == TX_REQ),
        .restart (1'b0),
        .expired (req_exp)
    );

    pfc_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .LIMIT_MS(GAP_MS)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st == TX_GAP),
        .restart (1'b0),
        .expired (gap_exp)
    );

    assign cts_fall  = cts_n_d && !cts_n_s;
    assign take_last = src_valid && ser_ready && src_last;

    // next-state selection per mode
    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE: begin
                if (pkt_pend) begin
                    if (mode == MODE_RAW)                st_nx = TX_SEND;
                    else if (mode == MODE_LEVEL)         st_nx = TX_REQ;
                    else if (cts_n_s)                    st_nx = TX_REQ;
                end
            end
            TX_REQ: begin
                if (mode == MODE_EDGE && cts_fall)       st_nx = TX_SEND;
                else if (mode != MODE_EDGE && !cts_n_s)  st_nx = TX_SEND;
            end
            TX_SEND:  if (take_last) st_nx = TX_DRAIN;
            TX_DRAIN: if (ser_idle)  st_nx = (mode == MODE_LEVEL) ? TX_GAP : TX_IDLE;
            TX_GAP:   if (gap_exp)   st_nx = TX_IDLE;
            default:  st_nx = TX_IDLE;
        endcase
    end

    // state register and clear-edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= TX_IDLE;
            cts_n_d <= 1'b1;
        end else begin
            st      <= st_nx;
            cts_n_d <= cts_n_s;
        end
    end

    // sticky timeout, cleared when a new request is raised
    always_ff @(posedge clk) begin
        if (!rst_n)                               tx_tmo <= 1'b0;
        else if (st == TX_IDLE && st_nx == TX_REQ) tx_tmo <= 1'b0;
        else if (st == TX_REQ && req_exp)         tx_tmo <= 1'b1;
    end

    assign tx_rts_n  = !((mode != MODE_RAW) &&
                         (st == TX_REQ || st == TX_SEND || st == TX_DRAIN));
    assign ser_valid = (st == TX_SEND) && src_valid;
    assign src_ready = (st == TX_SEND) && ser_ready;
    assign ser_data  = src_data;
endmodule

// File: rtl/pkt_flow_ctrl.sv
// Top of the packet handshake sequencer: decodes the mode, synchronizes
// the partner's asynchronous handshake inputs and joins the receive and
// transmit controllers. Assumes mode changes only while both sides idle.
module pkt_flow_ctrl
    import pfc_pkg::*;
#(
    parameter int DW         = 8,
    parameter int CLK_PER_MS = 125000,
    parameter int CLR_TMO_MS = 22,
    parameter int GAP_MS     = 100,
    parameter int ABORT_MS   = 100,
    parameter int SYNC_STG   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          rx_req_n,
    output logic          rx_clr_n,
    output logic          rx_en,
    input  logic          des_valid,
    input  logic          rx_eop,
    output logic          rx_abort,
    input  logic          pkt_pend,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    input  logic          src_last,
    output logic          src_ready,
    output logic          ser_valid,
    output logic [DW-1:0] ser_data,
    input  logic          ser_ready,
    input  logic          ser_idle,
    output logic          tx_rts_n,
    input  logic          tx_cts_n,
    output logic          tx_tmo
);
    mode_e      md;
    logic [1:0] hs_s;

    // spare code 3 falls back to no flow control
    always_comb begin
        unique case (mode)
            2'd1:    md = MODE_EDGE;
            2'd2:    md = MODE_LEVEL;
            default: md = MODE_RAW;
        endcase
    end

    pfc_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({tx_cts_n, rx_req_n}),
        .q     (hs_s)
    );

    pfc_rx_ctrl #(.CLK_PER_MS(CLK_PER_MS), .ABORT_MS(ABORT_MS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (md),
        .req_n_s   (hs_s[0]),
        .des_valid (des_valid),
        .rx_eop    (rx_eop),
        .rx_clr_n  (rx_clr_n),
        .rx_en     (rx_en),
        .rx_abort  (rx_abort)
    );

    pfc_tx_ctrl #(
        .DW(DW), .CLK_PER_MS(CLK_PER_MS),
        .CLR_TMO_MS(CLR_TMO_MS), .GAP_MS(GAP_MS)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (md),
        .cts_n_s   (hs_s[1]),
        .pkt_pend  (pkt_pend),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_last  (src_last),
        .src_ready (src_ready),
        .ser_valid (ser_valid),
        .ser_data  (ser_data),
        .ser_ready (ser_ready),
        .ser_idle  (ser_idle),
        .tx_rts_n  (tx_rts_n),
        .tx_tmo    (tx_tmo)
    );
endmodule

// File: rtl/pfc_checker.sv
// Protocol properties for the packet handshake sequencer, bound to the top.
module pfc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       rx_req_n,
    input logic       rx_clr_n,
    input logic       rx_abort,
    input logic       src_ready,
    input logic       ser_valid,
    input logic       ser_ready,
    input logic       tx_rts_n,
    input logic       tx_tmo
);
    AST_RAW_NO_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> tx_rts_n); // R2
    AST_BYTE_NEEDS_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && (mode == 2'd1 || mode == 2'd2)) |-> !tx_rts_n); // R4
    AST_CLR_AFTER_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_clr_n) && (mode == 2'd1 || mode == 2'd2)) |-> rx_req_n); // R3
    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort |=> !rx_abort); // R10
    AST_TMO_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_tmo) && mode != 2'd0) |-> !tx_rts_n); // R9
    AST_READY_FROM_SER: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> ser_ready); // R11
endmodule

bind pkt_flow_ctrl pfc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .rx_req_n  (rx_req_n),
    .rx_clr_n  (rx_clr_n),
    .rx_abort  (rx_abort),
    .src_ready (src_ready),
    .ser_valid (ser_valid),
    .ser_ready (ser_ready),
    .tx_rts_n  (tx_rts_n),
    .tx_tmo    (tx_tmo)
);

// File: tb/pkt_flow_ctrl_tb_top.sv
// Scoreboard bench: driver tasks queue bytes and expected values; a monitor
// compares each byte the serializer model accepts.
module pkt_flow_ctrl_tb_top;
    localparam int DW       = 8;
    localparam int CPM      = 20;
    localparam int TMO_MS   = 5;
    localparam int GAP_MS   = 10;
    localparam int ABT_MS   = 8;
    localparam int BYTE_CYC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic rx_req_n = 1'b1, des_valid = 1'b0, rx_eop = 1'b0;
    logic rx_clr_n, rx_en, rx_abort;
    logic pkt_pend = 1'b0, src_valid = 1'b0, src_last = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic src_ready, ser_valid;
    logic [DW-1:0] ser_data;
    logic ser_ready, ser_idle;
    logic tx_rts_n, tx_tmo;
    logic tx_cts_n = 1'b1;

    int n_chk = 0, n_fail = 0;
    int xfer_cnt = 0, abort_cnt = 0, busy = 0;
    bit rts_low_seen = 1'b0;
    logic [DW:0]   src_q [$];
    logic [DW-1:0] exp_q [$];

    always #4 clk = ~clk;

    pkt_flow_ctrl #(
        .DW(DW), .CLK_PER_MS(CPM), .CLR_TMO_MS(TMO_MS),
        .GAP_MS(GAP_MS), .ABORT_MS(ABT_MS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .rx_req_n(rx_req_n), .rx_clr_n(rx_clr_n), .rx_en(rx_en),
        .des_valid(des_valid), .rx_eop(rx_eop), .rx_abort(rx_abort),
        .pkt_pend(pkt_pend), .src_valid(src_valid), .src_data(src_data),
        .src_last(src_last), .src_ready(src_ready),
        .ser_valid(ser_valid), .ser_data(ser_data),
        .ser_ready(ser_ready), .ser_idle(ser_idle),
        .tx_rts_n(tx_rts_n), .tx_cts_n(tx_cts_n), .tx_tmo(tx_tmo)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: queue a packet and its expected bytes
    task automatic send_pkt(input int len, input logic [DW-1:0] base);
        for (int i = 0; i < len; i++) begin
            src_q.push_back({(i == len - 1), base + DW'(i)});
            exp_q.push_back(base + DW'(i));
        end
    endtask

    // serializer model: busy BYTE_CYC cycles per accepted byte
    always @(posedge clk) begin
        if (!rst_n) begin
            busy <= 0; ser_ready <= 1'b1; ser_idle <= 1'b1;
        end else if (ser_valid && ser_ready) begin
            busy <= BYTE_CYC; ser_ready <= 1'b0; ser_idle <= 1'b0;
        end else if (busy > 1) begin
            busy <= busy - 1;
        end else if (busy == 1) begin
            busy <= 0; ser_ready <= 1'b1; ser_idle <= 1'b1;
        end
        if (rst_n && src_valid && src_ready) void'(src_q.pop_front());
    end

    // source outputs and scoreboard monitor (R11)
    always @(negedge clk) begin
        pkt_pend  = (src_q.size() != 0);
        src_valid = pkt_pend;
        src_data  = pkt_pend ? src_q[0][DW-1:0] : '0;
        src_last  = pkt_pend ? src_q[0][DW] : 1'b0;
        #1;
        if (rst_n && ser_valid && ser_ready) begin
            xfer_cnt++;
            if (exp_q.size() == 0) check(1'b0, "R11 unexpected byte", ser_data, -1);
            else check(ser_data == exp_q[0], "R11 byte order", ser_data, exp_q[0]);
            if (exp_q.size() != 0) void'(exp_q.pop_front());
        end
        if (rst_n && rx_abort) abort_cnt++;
        if (rst_n && !tx_rts_n) rts_low_seen = 1'b1;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base, gap;
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check(rx_clr_n === 1'b1, "R1 rx_clr_n", rx_clr_n, 1);
        check(tx_rts_n === 1'b1, "R1 tx_rts_n", tx_rts_n, 1);
        check(ser_valid === 1'b0, "R1 ser_valid", ser_valid, 0);
        check(tx_tmo === 1'b0 && rx_abort === 1'b0, "R1 flags", tx_tmo, 0);

        // R2 no flow control
        check(rx_en === 1'b1 && rx_clr_n === 1'b1, "R2 rx lines", rx_en, 1);
        rts_low_seen = 1'b0;
        send_pkt(3, 8'h20);
        wait (exp_q.size() == 0);
        cyc(BYTE_CYC + 4);
        check(!rts_low_seen, "R2 rts stayed high", rts_low_seen, 0);
        check(xfer_cnt == 3, "R2 bytes streamed", xfer_cnt, 3);

        // R10 gap abort, then eop disarm
        des_valid = 1'b1; cyc(1); des_valid = 1'b0;
        cyc(ABT_MS * CPM - 10);
        check(abort_cnt == 0, "R10 no early abort", abort_cnt, 0);
        cyc(20);
        check(abort_cnt == 1, "R10 abort pulse", abort_cnt, 1);
        des_valid = 1'b1; cyc(1); des_valid = 1'b0;
        cyc(50);
        rx_eop = 1'b1; cyc(1); rx_eop = 1'b0;
        cyc(300);
        check(abort_cnt == 1, "R10 eop disarms", abort_cnt, 1);

        // R3 edge-mode receive handshake
        mode = 2'd1; cyc(2);
        check(rx_en === 1'b0, "R3 rx_en idle", rx_en, 0);
        rx_req_n = 1'b0; cyc(4);
        check(rx_clr_n === 1'b0 && rx_en === 1'b1, "R3 clear asserted", rx_clr_n, 0);
        rx_req_n = 1'b1; cyc(4);
        check(rx_clr_n === 1'b1 && rx_en === 1'b0, "R3 clear negated", rx_clr_n, 1);

        // R4/R5/R6 edge-mode transmit
        base = xfer_cnt;
        send_pkt(4, 8'h40);
        cyc(30);
        check(tx_rts_n === 1'b0, "R4 request raised", tx_rts_n, 0);
        check(xfer_cnt == base, "R4 no byte before edge", xfer_cnt, base);
        tx_cts_n = 1'b0;
        wait (xfer_cnt == base + 1);
        tx_cts_n = 1'b1;
        wait (exp_q.size() == 0);
        cyc(BYTE_CYC - 2);
        check(tx_rts_n === 1'b0, "R6 request held while draining", tx_rts_n, 0);
        cyc(5);
        check(tx_rts_n === 1'b1, "R6 request dropped", tx_rts_n, 1);
        check(xfer_cnt == base + 4, "R5 packet completes", xfer_cnt, base + 4);

        // R4 request withheld while clear is still low
        tx_cts_n = 1'b0; cyc(5);
        send_pkt(2, 8'h60);
        cyc(10);
        check(tx_rts_n === 1'b1, "R4 request withheld", tx_rts_n, 1);
        tx_cts_n = 1'b1; cyc(6);
        check(tx_rts_n === 1'b0, "R4 request after clear high", tx_rts_n, 0);
        tx_cts_n = 1'b0;
        wait (exp_q.size() == 0);
        cyc(BYTE_CYC + 4);
        tx_cts_n = 1'b1; cyc(4);

        // R9 clear-wait timeout
        send_pkt(2, 8'h70);
        wait (tx_rts_n == 1'b0);
        cyc(TMO_MS * CPM - 10);
        check(tx_tmo === 1'b0, "R9 no early timeout", tx_tmo, 0);
        cyc(15);
        check(tx_tmo === 1'b1, "R9 timeout set", tx_tmo, 1);
        tx_cts_n = 1'b0;
        wait (exp_q.size() == 0);
        cyc(BYTE_CYC + 4);
        check(tx_tmo === 1'b1, "R9 timeout sticky", tx_tmo, 1);
        tx_cts_n = 1'b1; cyc(4);
        send_pkt(1, 8'h78);
        wait (tx_rts_n == 1'b0);
        cyc(2);
        check(tx_tmo === 1'b0, "R9 cleared on new request", tx_tmo, 0);
        tx_cts_n = 1'b0;
        wait (exp_q.size() == 0);
        cyc(BYTE_CYC + 4);

        // R8 level-mode receive
        mode = 2'd2; cyc(2);
        check(rx_en === 1'b1, "R8 rx_en forced", rx_en, 1);
        rx_req_n = 1'b0; cyc(4);
        check(rx_clr_n === 1'b0, "R8 clear answers", rx_clr_n, 0);
        rx_req_n = 1'b1; cyc(4);
        check(rx_clr_n === 1'b1 && rx_en === 1'b1, "R8 clear released", rx_clr_n, 1);

        // R7 level-mode transmit with tied-low clear and gap
        send_pkt(3, 8'h80);
        wait (exp_q.size() == 0);
        wait (tx_rts_n == 1'b1);
        send_pkt(2, 8'h90);
        gap = 0;
        while (tx_rts_n === 1'b1 && gap < 1000) begin cyc(1); gap++; end
        check(gap >= GAP_MS * CPM && gap <= GAP_MS * CPM + 5, "R7 inter-packet gap", gap, GAP_MS * CPM);
        wait (exp_q.size() == 0);
        cyc(BYTE_CYC + 4);
        check(src_q.size() == 0, "R7 level packet sent", src_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule